// File: doc/BRIEF.md
# Low-Power Watch Mode Controller

This controller decides when a small microcontroller drops into its deepest clock-stopped standby state and when it comes back out. The CPU and most peripheral clocks stay gated off for the whole stay, while register and RAM contents are kept. Software requests entry by writing a request bit, together with a pin-mode bit, through a single write strobe. The request is honoured only while the slow subclock drives the system and no interrupt is pending. A request that fails either test is dropped for good.

The device leaves standby on a reset or on an interrupt whose priority is above the lowest level. The interrupt test ignores the CPU's global enable flag and its level mask. An interrupt wake releases the clock gates in the same cycle it is seen and sends the CPU a one-cycle wake pulse. A reset wake on a part with power-on reset first runs a stabilization wait of programmable length. A part without power-on reset gets its clocks back at once. Either kind of reset returns the pin-mode bit to its initial value.

Top module: `watch_ctl`

## Requirements
- R1: A write with `wr_en`=1 and `wr_watch`=1 enters standby only when `sub_clk_sel`=1. With `sub_clk_sel`=0 the write leaves the block running, with `watch_bit`=0 and both clock enables at 1.
- R2: If any bit of `irq_req` is 1 in the cycle of the request write, the request is discarded. Standby is not entered in any later cycle unless a new request is written.
- R3: In standby, `cpu_clk_en` and `per_clk_en` are 0 until a wake event. Outside standby and the stabilization wait, both are 1.
- R4: The pin-mode bit is taken from `wr_pin_float` on every write. In standby with bit 0, `pin_hold`=1 and `pin_float`=0. With bit 1, `pin_float`=1 and `pin_hold`=0. Outside standby both are 0.
- R5: Each interrupt line i has a 2-bit level in `irq_lvl[2i+1:2i]`, where 0 is the highest level and 3 the lowest. A pending line with level 0, 1 or 2 wakes the block. Level 3 never wakes it.
- R6: An interrupt wake raises `wake_pulse` for exactly one cycle and drives both clock enables to 1 in that same cycle. Afterwards `watch_bit` reads 0.
- R7: When `sys_rst` arrives in standby with `has_por`=1, `stab_wait` is 1 for `stab_count`+1 cycles with both clock enables at 0. `stab_done` is 1 only in the last of those cycles, and the block then runs.
- R8: When `sys_rst` arrives in standby with `has_por`=0, the clock enables go to 1 in that same cycle. `stab_wait` never rises, and the block runs from the next cycle.
- R9: A `sys_rst` clears the pin-mode bit, so `pin_float_bit` reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running subclock-domain clock |
| rst_n | input | 1 | Asynchronous power-up reset of the controller, active low |
| sys_rst | input | 1 | Chip reset event; acts as a wake source in standby |
| has_por | input | 1 | 1 when the part has power-on reset (stabilization wait needed) |
| sub_clk_sel | input | 1 | 1 when the system runs from the subclock |
| wr_en | input | 1 | Write strobe for the standby control bits |
| wr_watch | input | 1 | Standby request bit written with `wr_en` |
| wr_pin_float | input | 1 | Pin-mode bit written with `wr_en` (1 = high impedance) |
| irq_req | input | NIRQ | Pending interrupt requests |
| irq_lvl | input | 2*NIRQ | Two-bit priority level per request, 3 = lowest |
| stab_count | input | CNTW | Stabilization wait length in cycles minus one |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Gate enable for peripherals that stop in standby |
| pin_hold | output | 1 | Pins hold their last output values |
| pin_float | output | 1 | Pins go high impedance (pull-ups read high) |
| pin_float_bit | output | 1 | Readback of the pin-mode bit |
| watch_bit | output | 1 | Readback of the standby request bit; self-clears on wake |
| wake_pulse | output | 1 | One-cycle pulse on an interrupt wake |
| stab_wait | output | 1 | Oscillation stabilization wait in progress |
| stab_done | output | 1 | Last cycle of the stabilization wait |

## Verification
Entry is swept over every combination of clock select, pending interrupt and pin-mode bit. This separates the subclock gate from the pending-interrupt veto and shows which pin mode is applied. Wake is tried for every interrupt line at every priority level, which shows that only level 3 is filtered out and that each line position is decoded. Reset wake is run with power-on reset over a range of wait lengths, including zero, and without it. This measures the wait length exactly and confirms that clocks stay gated throughout.

// File: rtl/watch_ctl.sv
module watch_ctl #(
  parameter int NIRQ = 4,
  parameter int LVLW = 2,
  parameter int CNTW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sys_rst,
  input  logic                 has_por,
  input  logic                 sub_clk_sel,
  input  logic                 wr_en,
  input  logic                 wr_watch,
  input  logic                 wr_pin_float,
  input  logic [NIRQ-1:0]      irq_req,
  input  logic [NIRQ*LVLW-1:0] irq_lvl,
  input  logic [CNTW-1:0]      stab_count,
  output logic                 cpu_clk_en,
  output logic                 per_clk_en,
  output logic                 pin_hold,
  output logic                 pin_float,
  output logic                 pin_float_bit,
  output logic                 watch_bit,
  output logic                 wake_pulse,
  output logic                 stab_wait,
  output logic                 stab_done
);
  localparam logic [LVLW-1:0] LVL_LOWEST = '1;

  typedef enum logic [1:0] {S_RUN, S_WATCH, S_STAB} st_t;

  st_t             st;
  logic [CNTW-1:0] cnt;
  logic            float_q;
  logic [NIRQ-1:0] hi_pri;

  for (genvar i = 0; i < NIRQ; i++) begin : g_pri
    assign hi_pri[i] = irq_req[i] && (irq_lvl[i*LVLW +: LVLW] != LVL_LOWEST);
  end

  wire any_pend = |irq_req;
  wire in_watch = (st == S_WATCH);
  wire irq_wake = in_watch && (|hi_pri) && !sys_rst;
  wire rst_wake = in_watch && sys_rst;
  wire enter    = (st == S_RUN) && wr_en && wr_watch && sub_clk_sel && !any_pend && !sys_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RUN;
      cnt     <= '0;
      float_q <= 1'b0;
    end else begin
      if (sys_rst)
        float_q <= 1'b0;
      else if (wr_en && st == S_RUN)
        float_q <= wr_pin_float;
      case (st)
        S_RUN:   if (enter) st <= S_WATCH;
        S_WATCH: begin
          if (sys_rst) begin
            if (has_por) begin
              st  <= S_STAB;
              cnt <= stab_count;
            end else begin
              st <= S_RUN;
            end
          end else if (irq_wake) begin
            st <= S_RUN;
          end
        end
        S_STAB: begin
          if (sys_rst)          cnt <= stab_count;
          else if (cnt == '0)   st  <= S_RUN;
          else                  cnt <= cnt - 1'b1;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign cpu_clk_en    = (st == S_RUN) || irq_wake || (rst_wake && !has_por);
  assign per_clk_en    = cpu_clk_en;
  assign pin_hold      = in_watch && !float_q;
  assign pin_float     = in_watch && float_q;
  assign pin_float_bit = float_q;
  assign watch_bit     = in_watch;
  assign wake_pulse    = irq_wake;
  assign stab_wait     = (st == S_STAB);
  assign stab_done     = (st == S_STAB) && (cnt == '0) && !sys_rst;

  AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(watch_bit) |-> $past(sub_clk_sel && wr_en && wr_watch)) else $error("entry"); // R1
  AST_NO_PEND_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(watch_bit) |-> $past(irq_req == '0)) else $error("pend"); // R2
  AST_PIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_hold && pin_float)) else $error("pins"); // R4
  AST_WAKE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse && !watch_bit) else $error("wake"); // R6
  AST_STAB_END: assert property (@(posedge clk) disable iff (!rst_n)
    stab_done |=> !stab_wait && cpu_clk_en) else $error("stab"); // R7
  AST_STAB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    stab_wait |-> !cpu_clk_en && !per_clk_en) else $error("stabclk"); // R7
endmodule

// File: tb/sim_watch_ctl.sv
module sim_watch_ctl;
  logic clk = 0, rst_n = 0, sys_rst = 0, has_por = 0, sub_clk_sel = 0;
  logic wr_en = 0, wr_watch = 0, wr_pin_float = 0;
  logic [3:0] irq_req = '0;
  logic [7:0] irq_lvl = '1;
  logic [7:0] stab_count = '0;
  logic cpu_clk_en, per_clk_en, pin_hold, pin_float, pin_float_bit;
  logic watch_bit, wake_pulse, stab_wait, stab_done;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  watch_ctl u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic enter(input bit fl);
    sub_clk_sel = 1; wr_en = 1; wr_watch = 1; wr_pin_float = fl;
    step();
    wr_en = 0; wr_watch = 0;
  endtask

  task automatic leave_nopor();
    has_por = 0; sys_rst = 1;
    #1 chk(cpu_clk_en == 1, "R8", cpu_clk_en, 1);
    step();
    sys_rst = 0;
    #1;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    chk(cpu_clk_en == 1 && watch_bit == 0 && stab_wait == 0, "R3", cpu_clk_en, 1);
    rst_n = 1;
    step();

    for (int sc = 0; sc < 2; sc++)
      for (int pd = 0; pd < 2; pd++)
        for (int fl = 0; fl < 2; fl++) begin
          bit exp_w;
          exp_w = (sc == 1) && (pd == 0);
          sub_clk_sel = sc[0]; wr_en = 1; wr_watch = 1; wr_pin_float = fl[0];
          irq_req = pd[0] ? 4'b0001 : 4'b0000;
          irq_lvl = '1;
          step();
          wr_en = 0; wr_watch = 0; irq_req = '0;
          #1;
          chk(watch_bit == exp_w, pd ? "R2" : "R1", watch_bit, exp_w);
          chk(cpu_clk_en == !exp_w && per_clk_en == !exp_w, "R3", cpu_clk_en, !exp_w);
          chk(pin_float == (exp_w && fl == 1), "R4", pin_float, exp_w && fl == 1);
          chk(pin_hold == (exp_w && fl == 0), "R4", pin_hold, exp_w && fl == 0);
          chk(pin_float_bit == fl[0], "R4", pin_float_bit, fl);
          if (pd == 1) begin
            step(); step(); step();
            chk(watch_bit == 0, "R2", watch_bit, 0);
          end
          if (exp_w) begin
            leave_nopor();
            chk(watch_bit == 0 && stab_wait == 0, "R8", watch_bit, 0);
            chk(pin_float_bit == 0, "R9", pin_float_bit, 0);
          end
        end

    for (int ln = 0; ln < 4; ln++)
      for (int lv = 0; lv < 4; lv++) begin
        bit exp_k;
        exp_k = (lv != 3);
        enter(0);
        irq_lvl = '1;
        irq_lvl[ln*2 +: 2] = lv[1:0];
        irq_req = '0;
        irq_req[ln] = 1'b1;
        #1;
        chk(wake_pulse == exp_k, "R5", wake_pulse, exp_k);
        chk(cpu_clk_en == exp_k, "R6", cpu_clk_en, exp_k);
        step();
        irq_req = '0;
        #1;
        chk(wake_pulse == 0, "R6", wake_pulse, 0);
        chk(watch_bit == !exp_k, "R6", watch_bit, !exp_k);
        if (!exp_k) begin
          chk(cpu_clk_en == 0, "R3", cpu_clk_en, 0);
          leave_nopor();
        end
      end

    for (int k = 0; k < 6; k++) begin
      int n, done_at, done_cnt;
      enter(1);
      has_por = 1; stab_count = 8'(k); sys_rst = 1;
      #1 chk(cpu_clk_en == 0, "R7", cpu_clk_en, 0);
      step();
      sys_rst = 0;
      #1;
      n = 0; done_at = -1; done_cnt = 0;
      while (stab_wait && n < 50) begin
        if (cpu_clk_en) chk(0, "R7", cpu_clk_en, 0);
        if (stab_done) begin done_at = n; done_cnt++; end
        n++;
        step();
      end
      chk(n == k + 1, "R7", n, k + 1);
      chk(done_at == k && done_cnt == 1, "R7", done_at, k);
      chk(cpu_clk_en == 1 && watch_bit == 0, "R7", cpu_clk_en, 1);
      chk(pin_float_bit == 0, "R9", pin_float_bit, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule